// File: doc/BRIEF.md
# Program Flags Register with Branch Condition Tester

This block holds the processor's eight program flags and answers, within the same cycle, whether a branch condition is met. The flag byte is written from three sources: the ALU, which replaces selected flags under a per-bit mask; software, which stores a whole byte when it writes the register-file address that maps onto the flags; and three single-cycle carry commands (set, clear, invert). On each clock edge an arbiter picks one of four update sources: `UPD_HOLD`, `UPD_BYTE`, `UPD_CARRY` or `UPD_ALU`. The register then loads the matching next value.

The condition tester takes a 4-bit code from a jump or relative-branch opcode and decodes it against the current flags. The low three bits choose a test: never, signed less, signed less-or-equal, unsigned less-or-equal, overflow, minus, zero or carry. The top bit inverts the result. Code 0000b is therefore "never" and 1000b is "always". The output is purely combinational from the stored flags.

Top module: `flagc_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `flags_q` to 00h.
- R2: When `reg_wr_en` is high and `reg_wr_addr` equals FCh, all eight bits of `reg_wr_data` appear on `flags_q` after the next edge. A write to any other address, with no carry command and no ALU update, leaves `flags_q` unchanged.
- R3: A byte write to FCh wins over a carry command and an ALU update in the same cycle. Only the written byte is loaded.
- R4: `carry_cmd` is encoded as 00 none, 01 set C, 10 clear C and 11 invert C. A carry command changes only bit 7. It wins over an ALU update in the same cycle, and that ALU update is dropped.
- R5: With `alu_upd_en` high and no byte write or carry command, each of bits 7..2 whose `alu_mask` bit is 1 takes the matching `alu_flags` bit. Bits whose mask bit is 0 keep their value.
- R6: The user flags in bits 1 and 0 change only through a byte write to FCh. ALU mask bits 1..0 are ignored.
- R7: The flag byte layout is C bit 7, Z bit 6, S bit 5, V bit 4, D bit 3, H bit 2, user flag 2 bit 1 and user flag 1 bit 0. `flags_q` shows the register directly.
- R8: `cond_true` is 0 for code 0000b and 1 for code 1000b, whatever the flags hold.
- R9: Codes 0111b/1111b are true when C=1/C=0. Codes 0110b/1110b test Z=1/Z=0. Codes 0101b/1101b test S=1/S=0. Codes 0100b/1100b test V=1/V=0.
- R10: Code 1001b is true when S XOR V is 0, and code 0001b is true when S XOR V is 1.
- R11: Code 1010b is true when Z OR (S XOR V) is 0, and code 0010b is true when it is 1.
- R12: Code 1011b is true when C OR Z is 0, and code 0011b is true when C OR Z is 1.
- R13: `cond_true` follows `cond_code` and the current `flags_q` in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_en | input | 1 | Register-file write strobe |
| reg_wr_addr | input | 8 | Register-file write address |
| reg_wr_data | input | 8 | Register-file write data |
| alu_upd_en | input | 1 | ALU flag update strobe |
| alu_mask | input | 8 | Per-bit enable for the ALU update |
| alu_flags | input | 8 | Flag values from the ALU |
| carry_cmd | input | 2 | Carry command: 00 none, 01 set, 10 clear, 11 invert |
| cond_code | input | 4 | Branch condition code from the opcode |
| flags_q | output | 8 | Current flag byte |
| cond_true | output | 1 | Condition met |

## Verification
The clocked properties take for granted that the inputs are stable and known at every rising edge once reset is released. They also assume reset is held from time zero, so that one-cycle history is meaningful. The bench drives every input shortly after the falling edge and always to defined values. About half of its byte writes target FCh, so that all four update sources, and collisions between them, occur often. The immediate checks on the condition tester assume a defined `cond_code`, which the bench supplies from its first cycle.

// File: rtl/flagc_pkg.sv
package flagc_pkg;
    localparam int FLAG_W    = 8;
    localparam int USER_BITS = 2;
    localparam int BIT_C     = 7;
    localparam int BIT_Z     = 6;
    localparam int BIT_S     = 5;
    localparam int BIT_V     = 4;
    localparam logic [FLAG_W-1:0] USER_MASK = FLAG_W'((1 << USER_BITS) - 1);

    typedef enum logic [1:0] {
        CCMD_NONE = 2'b00,
        CCMD_SET  = 2'b01,
        CCMD_CLR  = 2'b10,
        CCMD_CPL  = 2'b11
    } carry_cmd_e;

    typedef enum logic [1:0] {
        UPD_HOLD  = 2'b00,
        UPD_BYTE  = 2'b01,
        UPD_CARRY = 2'b10,
        UPD_ALU   = 2'b11
    } upd_src_e;
endpackage

// File: rtl/flagc_arb.sv
module flagc_arb #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'hFC
) (
    input  logic                reg_wr_en,
    input  logic [ADDR_W-1:0]   reg_wr_addr,
    input  logic [1:0]          carry_cmd,
    input  logic                alu_upd_en,
    output flagc_pkg::upd_src_e src
);
    import flagc_pkg::*;

    logic hit;
    assign hit = reg_wr_en && (reg_wr_addr == FLAG_ADDR);

    // Fixed priority: byte write (R3), then carry command (R4), then ALU (R5)
    always_comb begin
        if (hit)
            src = UPD_BYTE;
        else if (carry_cmd != CCMD_NONE)
            src = UPD_CARRY;
        else if (alu_upd_en)
            src = UPD_ALU;
        else
            src = UPD_HOLD;
    end
endmodule

// File: rtl/flagc_reg.sv
module flagc_reg
    import flagc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  upd_src_e          src,
    input  logic [FLAG_W-1:0] wr_data,
    input  logic [1:0]        carry_cmd,
    input  logic [FLAG_W-1:0] alu_mask,
    input  logic [FLAG_W-1:0] alu_flags,
    output logic [FLAG_W-1:0] flags_q
);
    logic [FLAG_W-1:0] flags_d;
    logic [FLAG_W-1:0] eff_mask;

    assign eff_mask = alu_mask & ~USER_MASK;

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else
            flags_q <= flags_d;
    end

    always_comb begin
        flags_d = flags_q;
        unique case (src)
            UPD_HOLD:  flags_d = flags_q;
            UPD_BYTE:  flags_d = wr_data;
            UPD_CARRY: begin
                unique case (carry_cmd)
                    CCMD_SET:  flags_d[BIT_C] = 1'b1;
                    CCMD_CLR:  flags_d[BIT_C] = 1'b0;
                    CCMD_CPL:  flags_d[BIT_C] = ~flags_q[BIT_C];
                    default:   flags_d[BIT_C] = flags_q[BIT_C];
                endcase
            end
            UPD_ALU:   flags_d = (flags_q & ~eff_mask) | (alu_flags & eff_mask);
            default:   flags_d = flags_q;
        endcase
    end

    p_byte_load_r2: assert property (@(posedge clk) disable iff (rst)
        (src == UPD_BYTE) |=> (flags_q == $past(wr_data)));

    p_hold_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (src == UPD_HOLD) |=> $stable(flags_q));

    p_carry_only_r4: assert property (@(posedge clk) disable iff (rst)
        (src == UPD_CARRY) |=> (flags_q[BIT_C-1:0] == $past(flags_q[BIT_C-1:0])));

    p_carry_set_r4: assert property (@(posedge clk) disable iff (rst)
        (src == UPD_CARRY && carry_cmd == CCMD_SET) |=> flags_q[BIT_C]);

    p_carry_cpl_r4: assert property (@(posedge clk) disable iff (rst)
        (src == UPD_CARRY && carry_cmd == CCMD_CPL) |=> (flags_q[BIT_C] != $past(flags_q[BIT_C])));

    p_alu_masked_r5: assert property (@(posedge clk) disable iff (rst)
        (src == UPD_ALU) |=> (((flags_q ^ $past(flags_q)) & ~$past(alu_mask)) == '0));

    p_user_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (src != UPD_BYTE) |=> $stable(flags_q[USER_BITS-1:0]));
endmodule

// File: rtl/flagc_cond.sv
module flagc_cond
    import flagc_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    input  logic [3:0]        code,
    output logic              cond_true
);
    logic c_f, z_f, s_f, v_f, lt_f, base;

    assign c_f  = flags[BIT_C];
    assign z_f  = flags[BIT_Z];
    assign s_f  = flags[BIT_S];
    assign v_f  = flags[BIT_V];
    assign lt_f = s_f ^ v_f;

    // Low three bits choose the test, top bit inverts it
    always_comb begin
        unique case (code[2:0])
            3'b000:  base = 1'b0;
            3'b001:  base = lt_f;
            3'b010:  base = z_f | lt_f;
            3'b011:  base = c_f | z_f;
            3'b100:  base = v_f;
            3'b101:  base = s_f;
            3'b110:  base = z_f;
            default: base = c_f;
        endcase
    end

    assign cond_true = base ^ code[3];

    always_comb begin
        if (code == 4'b0000)
            p_never_false_r8: assert (!cond_true);
        if (code == 4'b1000)
            p_always_true_r8: assert (cond_true);
    end
endmodule

// File: rtl/flagc_unit.sv
module flagc_unit #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'hFC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [7:0]        reg_wr_data,
    input  logic              alu_upd_en,
    input  logic [7:0]        alu_mask,
    input  logic [7:0]        alu_flags,
    input  logic [1:0]        carry_cmd,
    input  logic [3:0]        cond_code,
    output logic [7:0]        flags_q,
    output logic              cond_true
);
    import flagc_pkg::*;

    upd_src_e src;

    flagc_arb #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_arb (
        .reg_wr_en  (reg_wr_en),
        .reg_wr_addr(reg_wr_addr),
        .carry_cmd  (carry_cmd),
        .alu_upd_en (alu_upd_en),
        .src        (src)
    );

    flagc_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .src      (src),
        .wr_data  (reg_wr_data),
        .carry_cmd(carry_cmd),
        .alu_mask (alu_mask),
        .alu_flags(alu_flags),
        .flags_q  (flags_q)
    );

    flagc_cond u_cond (
        .flags    (flags_q),
        .code     (cond_code),
        .cond_true(cond_true)
    );
endmodule

// File: tb/sim_flagc_unit.sv
module sim_flagc_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_addr = 8'h00;
    logic [7:0] reg_wr_data = 8'h00;
    logic       alu_upd_en = 1'b0;
    logic [7:0] alu_mask = 8'h00;
    logic [7:0] alu_flags = 8'h00;
    logic [1:0] carry_cmd = 2'b00;
    logic [3:0] cond_code = 4'b0000;
    logic [7:0] flags_q;
    logic       cond_true;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q = 8'h00;

    always #10 clk = ~clk;

    flagc_unit u0 (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .alu_upd_en(alu_upd_en), .alu_mask(alu_mask),
        .alu_flags(alu_flags), .carry_cmd(carry_cmd), .cond_code(cond_code),
        .flags_q(flags_q), .cond_true(cond_true)
    );

    function automatic logic model_cond(input logic [7:0] f, input logic [3:0] cc);
        logic c, z, s, v, r;
        c = f[7]; z = f[6]; s = f[5]; v = f[4];
        case (cc)
            4'b0000: r = 1'b0;
            4'b1000: r = 1'b1;
            4'b0111: r = c;
            4'b1111: r = !c;
            4'b0110: r = z;
            4'b1110: r = !z;
            4'b0101: r = s;
            4'b1101: r = !s;
            4'b0100: r = v;
            4'b1100: r = !v;
            4'b1001: r = (s ^ v) == 1'b0;
            4'b0001: r = (s ^ v) == 1'b1;
            4'b1010: r = (z | (s ^ v)) == 1'b0;
            4'b0010: r = (z | (s ^ v)) == 1'b1;
            4'b1011: r = (c | z) == 1'b0;
            default: r = (c | z) == 1'b1;
        endcase
        return r;
    endfunction

    function automatic string cond_tag(input logic [3:0] cc);
        case (cc[2:0])
            3'b000:                 return "R8";
            3'b001:                 return "R10";
            3'b010:                 return "R11";
            3'b011:                 return "R12";
            default:                return "R9";
        endcase
    endfunction

    function automatic logic [7:0] model_next(input logic [7:0] f, input logic we,
        input logic [7:0] a, input logic [7:0] d, input logic ae, input logic [7:0] m,
        input logic [7:0] af, input logic [1:0] cmd);
        logic [7:0] n, mm;
        n = f;
        mm = m & 8'hFC;
        if (we && a == 8'hFC) n = d;
        else if (cmd == 2'b01) n[7] = 1'b1;
        else if (cmd == 2'b10) n[7] = 1'b0;
        else if (cmd == 2'b11) n[7] = !f[7];
        else if (ae) n = (f & ~mm) | (af & mm);
        return n;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic we, input logic [7:0] a, input logic [7:0] d,
        input logic ae, input logic [7:0] m, input logic [7:0] af,
        input logic [1:0] cmd, input logic [3:0] cc, input string tag);
        logic [7:0] nxt;
        reg_wr_en = we; reg_wr_addr = a; reg_wr_data = d;
        alu_upd_en = ae; alu_mask = m; alu_flags = af;
        carry_cmd = cmd; cond_code = cc;
        #1;
        check(cond_tag(cc), {7'b0, cond_true}, {7'b0, model_cond(exp_q, cc)}); // R13 same cycle
        nxt = model_next(exp_q, we, a, d, ae, m, af, cmd);
        @(posedge clk); #1;
        check(tag, flags_q, nxt);
        if (!(we && a == 8'hFC))
            check("R6", {6'b0, flags_q[1:0]}, {6'b0, exp_q[1:0]});
        exp_q = nxt;
        @(negedge clk);
    endtask

    function automatic string path_tag(input logic we, input logic [7:0] a,
        input logic ae, input logic [1:0] cmd);
        if (we && a == 8'hFC) return (cmd != 0 || ae) ? "R3" : "R2";
        if (cmd != 2'b00) return "R4";
        if (ae) return "R5";
        return "R2";
    endfunction

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(posedge clk);
        #1;
        check("R1", flags_q, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        // R2: plain write and write elsewhere
        cycle(1, 8'hFC, 8'h5A, 0, 8'h00, 8'h00, 2'b00, 4'b1000, "R2");
        cycle(1, 8'hFB, 8'hFF, 0, 8'h00, 8'h00, 2'b00, 4'b0000, "R2");
        // R3: collision of all three sources
        cycle(1, 8'hFC, 8'h03, 1, 8'hFF, 8'hF0, 2'b11, 4'b0111, "R3");
        // R4: each carry command, with an ALU update that must be dropped
        cycle(0, 8'h00, 8'h00, 1, 8'hFF, 8'h7C, 2'b01, 4'b0111, "R4");
        cycle(0, 8'h00, 8'h00, 0, 8'h00, 8'h00, 2'b11, 4'b1111, "R4");
        cycle(0, 8'h00, 8'h00, 0, 8'h00, 8'h00, 2'b10, 4'b0111, "R4");
        // R5/R6: masked ALU update with user bits in mask
        cycle(0, 8'h00, 8'h00, 1, 8'h53, 8'hFF, 2'b00, 4'b0110, "R5");
        // R7: layout via byte write then bit-specific codes
        cycle(1, 8'hFC, 8'hA0, 0, 8'h00, 8'h00, 2'b00, 4'b0111, "R7");
        cycle(0, 8'h00, 8'h00, 0, 8'h00, 8'h00, 2'b00, 4'b0101, "R7");
        // R1 again: reset from a non-zero value
        rst = 1'b1;
        @(posedge clk); #1;
        check("R1", flags_q, 8'h00);
        exp_q = 8'h00;
        @(negedge clk);
        rst = 1'b0;

        // Exhaustive conditions over several flag patterns (R8-R12, R13)
        for (int p = 0; p < 16; p++) begin
            cycle(1, 8'hFC, {p[3:0], 4'h0}, 0, 8'h00, 8'h00, 2'b00, 4'b1000, "R2");
            for (int cc = 0; cc < 16; cc++)
                cycle(0, 8'h00, 8'h00, 0, 8'h00, 8'h00, 2'b00, cc[3:0], "R2");
        end

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic we, ae;
            logic [7:0] a, d, m, af;
            logic [1:0] cmd;
            logic [3:0] cc;
            we  = ($urandom % 4) == 0;
            a   = (($urandom % 2) == 0) ? 8'hFC : 8'($urandom);
            d   = 8'($urandom);
            ae  = ($urandom % 2) == 0;
            m   = 8'($urandom);
            af  = 8'($urandom);
            cmd = (($urandom % 3) == 0) ? 2'($urandom) : 2'b00;
            cc  = 4'($urandom);
            cycle(we, a, d, ae, m, af, cmd, cc, path_tag(we, a, ae, cmd));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule